// File: doc/BRIEF.md
# Two-Table Carry-Save Distributed-Arithmetic Dot Product

This block computes a signed eight-term dot product `sum(A_k * x_k)` without any multiplier. The coefficients `A_0..A_7` are fixed at build time. The samples `x_0..x_7` are loaded in parallel and then consumed one bit per clock, least significant bit first. Lanes 0 to 3 address one 16-word partial-sum table and lanes 4 to 7 address a second one. This avoids a single table of 256 words.

The two table words are merged in a registered bit-level carry-save array. In that array each cell keeps its own carry and feeds it back to itself, so no carry crosses a cell. The array's sum bits enter a carry-save shift accumulator built the same way. That accumulator hands out one finished low-order result bit per step. The deepest logic inside the iteration loop is therefore a single full adder, whatever the word width.

On the sign-bit step both table words are bit-inverted. The two `+1` terms that a true negation needs are left out. They are restored together as the constant 2 at the sign-bit weight, and this happens only in the carry-propagate adder that resolves the residual sums and carries after the last step. An extra clock flushes the carries still held in the array. A `start_i` pulse while idle launches one computation. `done_o` pulses for one cycle when `result_o` holds the new value.

Top module: `dadot_mac`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `busy_o` is 0, `done_o` is 0 and `result_o` is 0.
- R2: A `start_i` high at a clock edge where `busy_o` is low captures `samples_i`. Sample `k` sits at bits `[k*DATA_W +: DATA_W]`. `busy_o` is high from the next cycle.
- R3: `start_i` at an edge where `busy_o` is high is ignored. The running computation keeps its samples, its result and its timing.
- R4: `done_o` is a one-cycle pulse. It rises exactly `DATA_W+3` clock edges after the accepting edge (11 with the default width), and `busy_o` is low in that cycle.
- R5: When `done_o` is high, `result_o` equals the two's-complement value `sum(A_k * x_k)` over all eight lanes, `OUT_W = COEF_W+DATA_W+3` bits wide. Coefficients `A_0..A_3` are `COEF_LO[k*COEF_W +: COEF_W]` and feed the first table from samples 0 to 3. `A_4..A_7` are `COEF_HI[(k-4)*COEF_W +: COEF_W]` and feed the second table from samples 4 to 7.
- R6: Samples whose sign bit is set, including the most negative value `-2^(DATA_W-1)` and `-1`, give the exact signed product. The inverted sign step together with the deferred constant 2 must be exact.
- R7: Worst-case operands give the correct result without wrap-around. These are all samples at `-2^(DATA_W-1)`, or each sample at the extreme whose sign matches its coefficient.
- R8: `result_o` changes only at the edge that raises `done_o`, and holds its value while idle.
- R9: A `start_i` in the cycle where `done_o` is high is accepted, and the next result is correct and on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a computation when idle |
| samples_i | input | 8*DATA_W | Eight signed samples, lane k at bits k*DATA_W upward |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | OUT_W | Signed dot product |

## Verification
Single-lane unit samples give each coefficient back on its own, which shows that each lane reaches the right table and the right address bit. Group-only patterns keep one table at address zero and tell the two tables apart. All-ones and most-negative samples drive every step, including the inverted sign step, so a missing or misweighted compensation constant shows up at once. Extreme-magnitude operands catch width and wrap errors. Random samples cover mixed carry patterns. Pokes at `start_i` during a run, holds after a run and starts in the done cycle probe the control.

// File: rtl/dadot_pkg.sv
package dadot_pkg;
  localparam int unsigned LANES       = 8;
  localparam int unsigned GROUP_LANES = 4;
  localparam int unsigned GROUPS      = LANES / GROUP_LANES;
  localparam int unsigned TABLE_DEPTH = 1 << GROUP_LANES;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FINAL = 2'd2
  } dadot_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/dadot_sample_bank.sv
module dadot_sample_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    shift_i,
  input  logic [LANES*DATA_W-1:0] samples_i,
  output logic [LANES-1:0]        bits_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DATA_W-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q <= '0;
      else if (load_i)  sh_q <= samples_i[k*DATA_W +: DATA_W];
      else if (shift_i) sh_q <= sh_q >> 1;
    end
    assign bits_o[k] = sh_q[0];
  end
endmodule

// File: rtl/dadot_ptable.sv
module dadot_ptable
  import dadot_pkg::*;
#(
  parameter int unsigned                  COEF_W = 8,
  parameter int unsigned                  OUT_W  = 19,
  parameter logic [GROUP_LANES*COEF_W-1:0] COEFS = '0
) (
  input  logic [GROUP_LANES-1:0] addr_i,
  input  logic                   en_i,
  input  logic                   inv_i,
  output logic [OUT_W-1:0]       word_o
);
  // entries are sign-extended to the full result width so wrap is harmless
  function automatic logic [OUT_W-1:0] entry_val(input int unsigned e);
    logic [OUT_W-1:0]  acc;
    logic [COEF_W-1:0] c;
    acc = '0;
    for (int i = 0; i < int'(GROUP_LANES); i++) begin
      if (e[i]) begin
        c   = COEFS[i*COEF_W +: COEF_W];
        acc = acc + {{(OUT_W-COEF_W){c[COEF_W-1]}}, c};
      end
    end
    return acc;
  endfunction

  logic [OUT_W-1:0] rom [TABLE_DEPTH];
  logic [OUT_W-1:0] word;

  for (genvar e = 0; e < int'(TABLE_DEPTH); e++) begin : g_entry
    assign rom[e] = entry_val(e);
  end

  assign word   = rom[addr_i];
  assign word_o = en_i ? (inv_i ? ~word : word) : '0;
endmodule

// File: rtl/dadot_csa_array.sv
module dadot_csa_array
  import dadot_pkg::*;
#(
  parameter int unsigned OUT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [OUT_W-1:0] a_i,
  input  logic [OUT_W-1:0] b_i,
  output logic [OUT_W-1:0] sum_o
);
  logic [OUT_W-1:0] s_q, c_q, s_d, c_d;

  // carry stays in its cell: weight lines up one step later
  for (genvar j = 0; j < int'(OUT_W); j++) begin : g_cell
    assign s_d[j] = a_i[j] ^ b_i[j] ^ c_q[j];
    assign c_d[j] = maj3(a_i[j], b_i[j], c_q[j]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= '0;
      c_q <= '0;
    end else if (clr_i) begin
      s_q <= '0;
      c_q <= '0;
    end else if (en_i) begin
      s_q <= s_d;
      c_q <= c_d;
    end
  end

  assign sum_o = s_q;
endmodule

// File: rtl/dadot_csa_accum.sv
module dadot_csa_accum
  import dadot_pkg::*;
#(
  parameter int unsigned OUT_W = 19,
  parameter int unsigned LOW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [OUT_W-1:0] in_i,
  output logic [OUT_W-1:0] sum_o,
  output logic [OUT_W-1:0] carry_o,
  output logic [LOW_W-1:0] low_o
);
  logic [OUT_W-1:0] s_q, c_q, s_d, c_d, up;
  logic [LOW_W-1:0] low_q;

  for (genvar j = 0; j < int'(OUT_W); j++) begin : g_cell
    if (j == int'(OUT_W) - 1) begin : g_top
      assign up[j] = 1'b0;
    end else begin : g_mid
      assign up[j] = s_q[j+1];
    end
    assign s_d[j] = in_i[j] ^ up[j] ^ c_q[j];
    assign c_d[j] = maj3(in_i[j], up[j], c_q[j]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q   <= '0;
      c_q   <= '0;
      low_q <= '0;
    end else if (clr_i) begin
      s_q   <= '0;
      c_q   <= '0;
      low_q <= '0;
    end else if (en_i) begin
      s_q   <= s_d;
      c_q   <= c_d;
      low_q <= {s_d[0], low_q[LOW_W-1:1]};
    end
  end

  assign sum_o   = s_q;
  assign carry_o = c_q;
  assign low_o   = low_q;
endmodule

// File: rtl/dadot_ctrl.sv
module dadot_ctrl
  import dadot_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic shift_o,
  output logic tbl_en_o,
  output logic inv_o,
  output logic arr_en_o,
  output logic acc_en_o,
  output logic fin_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 2) + 1;
  localparam logic [CNT_W-1:0] K_SIGN  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] K_FLUSH = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] K_LAST  = CNT_W'(DATA_W + 1);

  dadot_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run;

  assign run = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
      end
      ST_RUN: begin
        if (cnt_q == K_LAST) state_d = ST_FINAL;
        else                 cnt_d   = cnt_q + 1'b1;
      end
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign tbl_en_o = run && (cnt_q < K_FLUSH);
  assign shift_o  = tbl_en_o;
  assign inv_o    = run && (cnt_q == K_SIGN);
  assign arr_en_o = run && (cnt_q <= K_FLUSH);
  assign acc_en_o = run && (cnt_q != '0);
  assign fin_o    = (state_q == ST_FINAL);
endmodule

// File: rtl/dadot_mac.sv
module dadot_mac
  import dadot_pkg::*;
#(
  parameter int unsigned  DATA_W  = 8,
  parameter int unsigned  COEF_W  = 8,
  parameter logic [4*COEF_W-1:0] COEF_LO = 32'h807FF903,
  parameter logic [4*COEF_W-1:0] COEF_HI = 32'hA664FF2D,
  localparam int unsigned OUT_W   = COEF_W + DATA_W + 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [8*DATA_W-1:0]   samples_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [OUT_W-1:0]      result_o
);
  localparam int unsigned LOW_W = DATA_W + 1;
  localparam int unsigned RES_W = OUT_W - LOW_W;
  // two deferred +1 terms at the sign-bit weight
  localparam logic [OUT_W-1:0] COMP = {{(OUT_W-1){1'b0}}, 1'b1} << DATA_W;

  logic                  load, shift, tbl_en, inv, arr_en, acc_en, fin;
  logic [LANES-1:0]      bits;
  logic [OUT_W-1:0]      tbl_word [GROUPS];
  logic [OUT_W-1:0]      arr_sum, acc_sum, acc_carry, residual, total;
  logic [LOW_W-1:0]      low;
  logic [OUT_W-1:0]      result_q;
  logic                  done_q;

  dadot_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk_i, .rst_ni, .start_i,
    .busy_o, .load_o(load), .shift_o(shift), .tbl_en_o(tbl_en),
    .inv_o(inv), .arr_en_o(arr_en), .acc_en_o(acc_en), .fin_o(fin)
  );

  dadot_sample_bank #(.DATA_W(DATA_W), .LANES(LANES)) i_bank (
    .clk_i, .rst_ni, .load_i(load), .shift_i(shift),
    .samples_i, .bits_o(bits)
  );

  for (genvar g = 0; g < int'(GROUPS); g++) begin : g_tbl
    dadot_ptable #(
      .COEF_W(COEF_W), .OUT_W(OUT_W),
      .COEFS((g == 0) ? COEF_LO : COEF_HI)
    ) i_ptable (
      .addr_i(bits[g*GROUP_LANES +: GROUP_LANES]),
      .en_i(tbl_en), .inv_i(inv), .word_o(tbl_word[g])
    );
  end

  dadot_csa_array #(.OUT_W(OUT_W)) i_array (
    .clk_i, .rst_ni, .clr_i(load), .en_i(arr_en),
    .a_i(tbl_word[0]), .b_i(tbl_word[1]), .sum_o(arr_sum)
  );

  dadot_csa_accum #(.OUT_W(OUT_W), .LOW_W(LOW_W)) i_accum (
    .clk_i, .rst_ni, .clr_i(load), .en_i(acc_en), .in_i(arr_sum),
    .sum_o(acc_sum), .carry_o(acc_carry), .low_o(low)
  );

  // carry-propagate resolution, only after the last step
  assign residual = (acc_sum >> 1) + acc_carry;
  assign total    = {residual[RES_W-1:0], low} + COMP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) result_q <= total;
    end
  end

  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/dadot_mac_chk.sv
module dadot_mac_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OUT_W  = 19
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [OUT_W-1:0] result_o
);
  localparam logic [15:0] LAT_AT_DONE = 16'(DATA_W + 4);

  logic [15:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat_q <= '0;
    else if (start_i && !busy_o)  lat_q <= 16'd1;
    else if (busy_o)              lat_q <= lat_q + 16'd1;
  end

  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R4
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LAT_AT_DONE)); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R8
endmodule

bind dadot_mac dadot_mac_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) i_dadot_mac_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/test_dadot_mac.sv
`timescale 1ns/1ps
module test_dadot_mac;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = CW + DW + 3;
  localparam logic [31:0] C_LO = 32'h807FF903; // 3, -7, 127, -128
  localparam logic [31:0] C_HI = 32'hA664FF2D; // 45, -1, 100, -90
  localparam int COEF [8] = '{3, -7, 127, -128, 45, -1, 100, -90};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [8*DW-1:0] samples = '0;
  logic            busy, done;
  logic [OW-1:0]   result;
  int              n_chk = 0;
  int              n_fail = 0;

  always #10 clk = ~clk;

  dadot_mac #(.DATA_W(DW), .COEF_W(CW), .COEF_LO(C_LO), .COEF_HI(C_HI)) i_dadot_mac (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .samples_i(samples),
    .busy_o(busy), .done_o(done), .result_o(result)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_dot(input int s[8]);
    longint acc = 0;
    for (int k = 0; k < 8; k++) acc += longint'(COEF[k]) * longint'(s[k]);
    return acc;
  endfunction

  // starts at the current negedge, returns at the negedge where done is seen
  task automatic run_op(input int s[8], input int poke, input string req);
    logic [8*DW-1:0]        pk;
    logic signed [OW-1:0]   e;
    int                     lat;
    for (int k = 0; k < 8; k++) pk[k*DW +: DW] = DW'(s[k]);
    e = OW'(ref_dot(s));
    samples = pk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    lat = 0;
    while (!done && lat < 60) begin
      if (lat == poke) begin
        samples = ~pk;
        start   = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check(lat == DW + 3, "R4 latency", lat, DW + 3);
    check(busy == 1'b0, "R4 idle at done", longint'(busy), 0);
    check($signed(result) == e, req, longint'($signed(result)), longint'(e));
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R1 busy", longint'(busy), 0);
    check(done == 1'b0, "R1 done", longint'(done), 0);
    check(result == '0, "R1 result", longint'(result), 0);
  endtask

  task automatic t_single_lane();
    for (int k = 0; k < 8; k++) begin
      int s[8] = '{default: 0};
      s[k] = 1;
      run_op(s, -1, "R5 single lane");
      @(negedge clk);
    end
  endtask

  task automatic t_groups();
    run_op('{5, -3, 17, 2, 0, 0, 0, 0}, -1, "R5 low table only");
    @(negedge clk);
    run_op('{0, 0, 0, 0, -9, 77, 1, -4}, -1, "R5 high table only");
    @(negedge clk);
  endtask

  task automatic t_sign();
    run_op('{default: -1}, -1, "R6 all minus one");
    @(negedge clk);
    run_op('{default: -128}, -1, "R6 most negative");
    @(negedge clk);
    run_op('{-128, 0, 0, 0, 0, 0, 0, -128}, -1, "R6 sparse sign");
    @(negedge clk);
  endtask

  task automatic t_extreme();
    run_op('{127, -128, 127, -128, 127, -128, 127, -128}, -1, "R7 max positive");
    @(negedge clk);
    run_op('{-128, 127, -128, 127, -128, 127, -128, 127}, -1, "R7 max negative");
    @(negedge clk);
  endtask

  task automatic t_busy_start();
    run_op('{10, 20, -30, 40, -50, 60, -70, 80}, 3, "R3 start while busy ignored");
    @(negedge clk);
  endtask

  task automatic t_hold();
    logic [OW-1:0] held;
    run_op('{1, 2, 3, 4, 5, 6, 7, 8}, -1, "R8 result before hold");
    held = result;
    repeat (5) begin
      @(negedge clk);
      check(result == held, "R8 result held", longint'(result), longint'(held));
      check(done == 1'b0, "R4 done single cycle", longint'(done), 0);
    end
  endtask

  task automatic t_back2back();
    run_op('{-1, 2, -3, 4, -5, 6, -7, 8}, -1, "R9 first of pair");
    run_op('{100, -100, 50, -50, 25, -25, 12, -12}, -1, "R9 started in done cycle");
    @(negedge clk);
  endtask

  task automatic t_random();
    for (int n = 0; n < 24; n++) begin
      int s[8];
      for (int k = 0; k < 8; k++) s[k] = int'($urandom_range(255)) - 128;
      run_op(s, -1, "R5 random");
      if (n % 3 == 0) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_lane();
    t_groups();
    t_sign();
    t_extreme();
    t_busy_start();
    t_hold();
    t_back2back();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule